// File: doc/BRIEF.md
# BCH error location bit flipper

This block applies the corrections that a BCH8 error locator has found to one 512-byte sector. The sector sits in a local single-port byte RAM inside the block. The caller presents three things and pulses `start`: an error count, up to eight bit positions in codeword order, and the 14 ECC bytes that were read from the spare area. In codeword order the 104 ECC bits come first, and the data bits follow in reverse byte order.

The engine walks the position list in list order. A position inside the ECC span is passed over. Any other position is remapped to a byte address and a one-hot mask. The engine then does a three-cycle read-modify-write that toggles the addressed bit. The list is skipped completely in two cases: when every stored ECC byte reads as erased flash, and when the count is out of range. In the second case the block raises an error flag.

Between jobs a host port preloads the sector and reads it back. Host writes have no effect while a job is running.

Top module: `bch_bitfix`

## Requirements
- R1: After reset `busy`, `done` and `errFlag` are all 0.
- R2: A location in 0..103 (inside the ECC bit span) leaves the sector unchanged.
- R3: For a location L in 104..4199, with A = L - 104, the bit (A mod 8) of byte (4095 - A) / 8 is inverted (XOR). Location 104 hits byte 511 bit 0, and location 4199 hits byte 0 bit 7.
- R4: Exactly the first `errCount` entries of `errLocs` are applied, in entry order. Entry i is `errLocs[i*13 +: 13]`. Entries at or beyond the count have no effect. The same location given twice restores the bit.
- R5: If all 14 bytes of `storedEcc` equal 0xFF, no byte is written, `errFlag` stays 0, and `done` is high right after the edge that samples `start`.
- R6: An `errCount` above 8 writes nothing, and `done` and `errFlag` are both high right after the edge that samples `start`. `errFlag` holds its value until the next job starts.
- R7: Number the edge that samples `start` as 1. For a job that is neither rejected nor erased, `done` is high after edge 2 + S + 3*D, where S is the number of applied entries that are skipped and D is the number that are written.
- R8: A location of 4200 or more leaves the sector unchanged and costs one cycle, like an ECC-span location.
- R9: While idle, a host write stores `hostWdata` at `hostAddr`, and `hostRdata` shows the byte at `hostAddr` one cycle later. A host write while `busy` is high has no effect.
- R10: `done` is a one-cycle pulse. On the cycle after `done`, both `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; sampled only while idle |
| errCount | input | 4 | Number of valid location entries |
| errLocs | input | 104 | Eight 13-bit codeword bit locations, entry i at [i*13 +: 13] |
| storedEcc | input | 112 | The 14 ECC bytes read from the spare area |
| busy | output | 1 | Job in progress; host port locked out |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last job was rejected for an out-of-range count |
| hostWe | input | 1 | Host write strobe (idle only) |
| hostAddr | input | 9 | Host byte address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, one cycle after the address |

## Verification
The bench builds the block with its default values: a 512-byte sector, 26 ECC nibbles and eight locations. These defaults put both ends of the data region within reach: location 104 maps to the last byte and location 4199 maps to bit 7 of byte 0. The bench also drives locations just beyond both ends of the data region, a full list of eight, and the counts 9 and 15 that must be refused. Every job's completion cycle is compared with a latency model built from the skip and write counts. A host write issued in the middle of a job shows whether the engine really holds the RAM port while `busy` is high.

// File: rtl/bitfix_pkg.sv
package bitfix_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latch;       // capture job inputs, clear index
    logic advance;     // move to next list entry
    logic loadTarget;  // register byte address and mask of current entry
    logic ramRead;     // issue read of target byte
    logic ramWrite;    // write back toggled byte
  } fixStrobe_t;

  // Conditions reported by the datapath
  typedef struct packed {
    logic listEnd;     // index reached the captured count
    logic locInData;   // current entry maps into the sector
    logic eccErased;   // every stored ECC byte is 0xFF
    logic countBad;    // presented count exceeds the list size
  } fixStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } fixState_t;

endpackage

// File: rtl/bitfix_ram.sv
module bitfix_ram #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [7:0] mem [DEPTH];

  // Single port, read-before-write, one cycle read latency
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/bitfix_ctrl.sv
module bitfix_ctrl
  import bitfix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  fixStatus_t st,
  output fixStrobe_t stb,
  output logic       engaged,
  output logic       done,
  output logic       errFlag
);

  fixState_t stateQ, stateNext;
  logic      errQ;

  always_comb begin
    stb       = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.latch = 1'b1;
          if (st.countBad || st.eccErased) stateNext = ST_FIN;
          else                             stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (st.listEnd) begin
          stateNext = ST_FIN;
        end else if (st.locInData) begin
          stb.loadTarget = 1'b1;
          stateNext      = ST_READ;
        end else begin
          stb.advance = 1'b1;
        end
      end
      ST_READ: begin
        stb.ramRead = 1'b1;
        stateNext   = ST_WRITE;
      end
      ST_WRITE: begin
        stb.ramWrite = 1'b1;
        stb.advance  = 1'b1;
        stateNext    = ST_SCAN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stb.latch) errQ <= st.countBad;
    end
  end

  assign engaged = (stateQ == ST_SCAN) || (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign done    = (stateQ == ST_FIN);
  assign errFlag = errQ;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !engaged));

  p_reject_fast_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start && st.countBad) |=> (done && errFlag));

  p_erased_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start && !st.countBad && st.eccErased) |=> (done && !errFlag));

endmodule

// File: rtl/bitfix_dp.sv
module bitfix_dp
  import bitfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_NIBBLES  = 26,
  parameter int MAX_ERRS     = 8,
  parameter int ECC_BYTES    = 14,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int SECTOR_BITS = SECTOR_BYTES * 8,
  localparam int ECC_BITS    = ECC_NIBBLES * 4,
  localparam int LOC_W       = $clog2(SECTOR_BITS + ECC_BITS),
  localparam int CNT_W       = $clog2(MAX_ERRS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fixStrobe_t                stb,
  input  logic                      engaged,
  output fixStatus_t                st,
  input  logic [CNT_W-1:0]          errCount,
  input  logic [MAX_ERRS*LOC_W-1:0] errLocs,
  input  logic [ECC_BYTES*8-1:0]    storedEcc,
  input  logic                      hostWe,
  input  logic [ADDR_W-1:0]         hostAddr,
  input  logic [7:0]                hostWdata,
  output logic [7:0]                hostRdata
);

  logic [LOC_W-1:0]  locQ [MAX_ERRS];
  logic [CNT_W-1:0]  cntQ, idxQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        maskQ;

  logic [LOC_W-1:0]  locCur, adjLoc, revBit;
  logic [LOC_W:0]    locWide;
  logic [ADDR_W-1:0] byteAddr;
  logic [7:0]        bitMask;

  // Current entry select
  always_comb begin
    locCur = '0;
    for (int i = 0; i < MAX_ERRS; i++)
      if (idxQ == CNT_W'(i)) locCur = locQ[i];
  end

  // Codeword to sector mapping: drop the ECC span, reverse the byte order
  assign locWide  = {1'b0, locCur};
  assign adjLoc   = locCur - LOC_W'(ECC_BITS);
  assign revBit   = LOC_W'(SECTOR_BITS - 1) - adjLoc;
  assign byteAddr = ADDR_W'(revBit >> 3);
  assign bitMask  = 8'd1 << adjLoc[2:0];

  assign st.listEnd   = (idxQ == cntQ);
  assign st.locInData = (locWide >= (LOC_W+1)'(ECC_BITS)) &&
                        (locWide <  (LOC_W+1)'(ECC_BITS + SECTOR_BITS));
  assign st.eccErased = &storedEcc;
  assign st.countBad  = (errCount > CNT_W'(MAX_ERRS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      idxQ  <= '0;
      addrQ <= '0;
      maskQ <= '0;
      for (int i = 0; i < MAX_ERRS; i++) locQ[i] <= '0;
    end else begin
      if (stb.latch) begin
        cntQ <= errCount;
        idxQ <= '0;
        for (int i = 0; i < MAX_ERRS; i++) locQ[i] <= errLocs[i*LOC_W +: LOC_W];
      end else if (stb.advance) begin
        idxQ <= idxQ + 1'b1;
      end
      if (stb.loadTarget) begin
        addrQ <= byteAddr;
        maskQ <= bitMask;
      end
    end
  end

  // RAM port: engine owns it while engaged, host otherwise
  logic              ramEn, ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0]        ramWdata, ramRdata;

  assign ramEn    = engaged ? (stb.ramRead | stb.ramWrite) : 1'b1;
  assign ramWe    = engaged ? stb.ramWrite : hostWe;
  assign ramAddr  = engaged ? addrQ : hostAddr;
  assign ramWdata = engaged ? (ramRdata ^ maskQ) : hostWdata;
  assign hostRdata = ramRdata;

  bitfix_ram #(.DEPTH(SECTOR_BYTES), .ADDR_W(ADDR_W)) uRam (
    .clk   (clk),
    .en    (ramEn),
    .we    (ramWe),
    .addr  (ramAddr),
    .wdata (ramWdata),
    .rdata (ramRdata)
  );

  p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWrite |-> ($past(stb.ramRead) && $stable(addrQ)));

  p_target_in_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTarget |-> (locCur >= LOC_W'(ECC_BITS)));

  p_index_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    engaged |-> (idxQ <= cntQ));

  p_one_bit_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWrite |-> ($countones(maskQ) == 1));

endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix
  import bitfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_NIBBLES  = 26,
  parameter int MAX_ERRS     = 8,
  parameter int ECC_BYTES    = 14,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int LOC_W       = $clog2(SECTOR_BYTES * 8 + ECC_NIBBLES * 4),
  localparam int CNT_W       = $clog2(MAX_ERRS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [CNT_W-1:0]          errCount,
  input  logic [MAX_ERRS*LOC_W-1:0] errLocs,
  input  logic [ECC_BYTES*8-1:0]    storedEcc,
  output logic                      busy,
  output logic                      done,
  output logic                      errFlag,
  input  logic                      hostWe,
  input  logic [ADDR_W-1:0]         hostAddr,
  input  logic [7:0]                hostWdata,
  output logic [7:0]                hostRdata
);

  fixStrobe_t stb;
  fixStatus_t st;
  logic       engaged;

  bitfix_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .st      (st),
    .stb     (stb),
    .engaged (engaged),
    .done    (done),
    .errFlag (errFlag)
  );

  bitfix_dp #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .ECC_NIBBLES  (ECC_NIBBLES),
    .MAX_ERRS     (MAX_ERRS),
    .ECC_BYTES    (ECC_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .engaged   (engaged),
    .st        (st),
    .errCount  (errCount),
    .errLocs   (errLocs),
    .storedEcc (storedEcc),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata)
  );

  assign busy = engaged;

endmodule

// File: tb/bch_bitfix_test.sv
module bch_bitfix_test;

  localparam int NBYTES = 512;
  localparam int LOC_W  = 13;
  localparam int NLOC   = 8;
  localparam int LOCS_W = NLOC * LOC_W;
  localparam int ECC_W  = 14 * 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        errCount = '0;
  logic [LOCS_W-1:0] errLocs = '0;
  logic [ECC_W-1:0]  storedEcc = '0;
  logic              busy, done, errFlag;
  logic              hostWe = 1'b0;
  logic [8:0]        hostAddr = '0;
  logic [7:0]        hostWdata = '0;
  logic [7:0]        hostRdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [NBYTES];

  always #5 clk = ~clk;

  bch_bitfix uut (
    .clk(clk), .rstN(rstN), .start(start), .errCount(errCount),
    .errLocs(errLocs), .storedEcc(storedEcc), .busy(busy), .done(done),
    .errFlag(errFlag), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [LOCS_W-1:0] packLocs(input int l0, l1, l2, l3,
                                                 l4, l5, l6, l7);
    int v [NLOC];
    logic [LOCS_W-1:0] p;
    v = '{l0, l1, l2, l3, l4, l5, l6, l7};
    p = '0;
    for (int i = 0; i < NLOC; i++) p[i*LOC_W +: LOC_W] = LOC_W'(v[i]);
    return p;
  endfunction

  // Reference mapping written from R3 / R2 / R8
  function automatic bit inData(input int loc);
    return (loc >= 104) && (loc < 4200);
  endfunction

  task automatic preload();
    for (int a = 0; a < NBYTES; a++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = 9'(a); hostWdata = 8'(a * 37) ^ 8'h5A;
      mdl[a] = hostWdata;
    end
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic verifyRam(input string req);
    int bad = 0; int firstA = -1; int act = 0; int exp = 0;
    for (int a = 0; a < NBYTES; a++) begin
      @(negedge clk);
      hostAddr = 9'(a);
      @(negedge clk);
      if (hostRdata !== mdl[a]) begin
        if (firstA < 0) begin firstA = a; act = hostRdata; exp = mdl[a]; end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("sector byte %0d", firstA), act, exp);
  endtask

  task automatic runJob(input string req, input int cnt,
                        input logic [LOCS_W-1:0] locs,
                        input logic [ECC_W-1:0] ecc, input bit poke);
    int expN; int n = 0; bit expErr; string latReq; int loc;
    expErr = (cnt > 8);
    if (expErr)      begin expN = 1; latReq = "R6"; end
    else if (&ecc)   begin expN = 1; latReq = "R5"; end
    else begin
      latReq = "R7";
      expN = 2;
      for (int i = 0; i < cnt; i++) begin
        loc = int'(locs[i*LOC_W +: LOC_W]);
        if (inData(loc)) begin
          expN += 3;
          mdl[(4095 - (loc - 104)) / 8] ^= 8'(1 << ((loc - 104) % 8));
        end else expN += 1;
      end
    end
    @(negedge clk);
    errCount = 4'(cnt); errLocs = locs; storedEcc = ecc; start = 1'b1;
    while (n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      hostWe = poke && busy;
      hostAddr = 9'd7; hostWdata = ~mdl[7];
      if (done) break;
    end
    hostWe = 1'b0;
    check(n == expN, latReq, "done latency", n, expN);
    check(errFlag == expErr, "R6", "errFlag at done", errFlag, expErr);
    @(negedge clk);
    check(!done && !busy, "R10", "done/busy after pulse", {done, busy}, 0);
  endtask

  localparam logic [ECC_W-1:0] ECC_OK = {14{8'h3C}};
  localparam logic [ECC_W-1:0] ECC_FF = {14{8'hFF}};

  task automatic t_reset();
    check(!busy,    "R1", "busy after reset", busy, 0);
    check(!done,    "R1", "done after reset", done, 0);
    check(!errFlag, "R1", "errFlag after reset", errFlag, 0);
  endtask

  task automatic t_host();
    preload();
    verifyRam("R9");
  endtask

  task automatic t_edges();
    runJob("R3", 3, packLocs(104, 4199, 1234, 0, 0, 0, 0, 0), ECC_OK, 0);
    verifyRam("R3");
  endtask

  task automatic t_ecc_span();
    runJob("R2", 3, packLocs(0, 50, 103, 0, 0, 0, 0, 0), ECC_OK, 0);
    verifyRam("R2");
  endtask

  task automatic t_beyond();
    runJob("R8", 2, packLocs(4200, 8191, 0, 0, 0, 0, 0, 0), ECC_OK, 0);
    verifyRam("R8");
  endtask

  task automatic t_count();
    // entries 0 and 1 cancel; entries 5..7 lie past the count
    runJob("R4", 5, packLocs(2000, 2000, 60, 3000, 700, 900, 1500, 4100), ECC_OK, 0);
    verifyRam("R4");
    runJob("R4", 8, packLocs(105, 111, 230, 1777, 2600, 3333, 4000, 4198), ECC_OK, 0);
    verifyRam("R4");
  endtask

  task automatic t_erased();
    runJob("R5", 3, packLocs(500, 600, 700, 0, 0, 0, 0, 0), ECC_FF, 0);
    verifyRam("R5");
    // a single non-FF byte disables the bypass
    runJob("R5", 1, packLocs(500, 0, 0, 0, 0, 0, 0, 0), {8'hFE, {13{8'hFF}}}, 0);
    verifyRam("R5");
  endtask

  task automatic t_reject();
    runJob("R6", 9, packLocs(500, 600, 700, 800, 900, 1000, 1100, 1200), ECC_OK, 0);
    verifyRam("R6");
    runJob("R6", 15, packLocs(500, 0, 0, 0, 0, 0, 0, 0), ECC_OK, 0);
    check(errFlag == 1'b1, "R6", "errFlag held after job", errFlag, 1);
    verifyRam("R6");
  endtask

  task automatic t_busy_host();
    runJob("R9", 4, packLocs(1000, 1100, 1200, 1300, 0, 0, 0, 0), ECC_OK, 1);
    verifyRam("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_host();
    t_edges();
    t_ecc_span();
    t_beyond();
    t_count();
    t_erased();
    t_reject();
    t_busy_host();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule